// File: doc/BRIEF.md
# Priority-Level Maskable Interrupt Controller

This block arbitrates among a parameterised number of maskable interrupt sources (24 by default). Every source has a byte-wide control register on a simple register bus. The register carries a 3-bit priority level and a pending flag. A request input per source sets the pending flag. The input may be held as a level or given as a single-cycle pulse. Software can only clear the flag. The CPU supplies a global enable and its current processor priority level (IPL). The block presents one winning source to the CPU, giving its index and level, and clears that source's flag when the CPU acknowledges it.

Selection is driven by a three-state machine:

- **IDLE**: no interrupt is presented. Transition *raise*: IDLE goes to ASSERT when an eligible source exists.
- **ASSERT**: `irq_out` is high. Transition *hold*: ASSERT stays in ASSERT, with index and level following the current winner, while an eligible source remains. Transition *withdraw*: ASSERT goes to IDLE when no eligible source remains. Transition *accept*: ASSERT goes to RECOVER when the CPU acknowledges.
- **RECOVER**: a one-cycle gap after an acknowledge, so the cleared source is never presented twice. Transition *resume*: RECOVER goes to ASSERT when a winner exists. Transition *settle*: RECOVER goes to IDLE otherwise.

The outputs are registered. They reflect the flags, levels, enable and IPL of the preceding cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every control register reads 0x00, and `irq_out`, `irq_idx` and `irq_lvl` are 0.
- R2: In each register, bits 2:0 hold the level and can be read and written. Bits 7:4 ignore writes and read as 0. Any address at or above NUM_SRC reads 0x00 and ignores writes.
- R3: A source whose request input is 1 in a cycle has its flag (bit 3) set at that clock edge. The flag stays set after the input returns to 0.
- R4: Writing a control register with bit 3 = 0 clears the flag. Writing it with bit 3 = 1 leaves the flag unchanged.
- R5: A request in the same cycle as a software clear, or as an acknowledge of the same source, leaves the flag set.
- R6: A source is eligible only when its flag is 1, the global enable is 1, and its level is strictly greater than `cpu_ipl`. Level 0 is therefore never eligible. `irq_out` is 1 only when an eligible source exists.
- R7: Among eligible sources the highest level wins. Between equal levels, the lowest index wins.
- R8: When `irq_ack` is 1 while `irq_out` is 1, the flag of the presented source `irq_idx` is cleared. `irq_out` is then 0 for exactly the next cycle, after which selection is made again.
- R9: `irq_out`, `irq_idx` and `irq_lvl` are registered. They reflect the state of the cycle before the edge. While `irq_out` is 0, `irq_idx` and `irq_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register index (one per source) |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| src_req | input | NUM_SRC | Request input, one bit per source |
| glb_en | input | 1 | Global maskable-interrupt enable |
| cpu_ipl | input | 3 | Processor priority level |
| irq_out | output | 1 | Interrupt presented to the CPU |
| irq_idx | output | IDX_W | Index of the presented source |
| irq_lvl | output | 3 | Level of the presented source |
| irq_ack | input | 1 | CPU acknowledge of the presented source |

## Verification
The bench targets the following corner cases:

- **Software writing 1 to the flag bit.** A design that let this through would raise spurious interrupts.
- **A request arriving on the same edge as a clear.** A design that got the precedence wrong would silently lose the request.
- **A level exactly equal to the IPL.** A comparison with the wrong sense would accept an interrupt it must mask.
- **Equal levels.** A design with the wrong tie-break would present the wrong index.
- **The cycle right after an acknowledge.** A design without the recovery gap would present the just-cleared source again, and the CPU would accept it twice.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W = 3;
    localparam int REG_W = 8;
    localparam int FLAG_BIT = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ASSERT  = 2'd1,
        ST_RECOVER = 2'd2
    } irq_state_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int ADDR_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [REG_W-1:0]              reg_wdata,
    input  logic                          reg_we,
    output logic [REG_W-1:0]              reg_rdata,
    input  logic [NUM_SRC-1:0]            src_req,
    input  logic [NUM_SRC-1:0]            ack_clr,
    output logic [NUM_SRC-1:0]            flag_q,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic sel;
        logic sw_clr;
        assign sel    = reg_we && (reg_addr == ADDR_W'(i));
        assign sw_clr = sel && !reg_wdata[FLAG_BIT];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
                lvl_q[i]  <= '0;
            end else begin
                flag_q[i] <= src_req[i] || (flag_q[i] && !sw_clr && !ack_clr[i]);
                if (sel) lvl_q[i] <= reg_wdata[LVL_W-1:0];
            end
        end

        assert_req_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[i] |=> flag_q[i]);
        assert_one_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && reg_wdata[FLAG_BIT] && !src_req[i] && !flag_q[i]) |=> !flag_q[i]);
        assert_req_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (src_req[i] && (sw_clr || ack_clr[i])) |=> flag_q[i]);
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_addr == ADDR_W'(i))
                reg_rdata = {{(REG_W-LVL_W-1){1'b0}}, flag_q[i], lvl_q[i]};
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 24,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            flag_q,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q,
    input  logic                          glb_en,
    input  logic [LVL_W-1:0]              cpu_ipl,
    output logic                          win_valid,
    output logic [IDX_W-1:0]              win_idx,
    output logic [LVL_W-1:0]              win_lvl
);
    always_comb begin
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (glb_en && flag_q[i] && (lvl_q[i] > cpu_ipl) && (lvl_q[i] > win_lvl)) begin
                win_idx = IDX_W'(i);
                win_lvl = lvl_q[i];
            end
        end
        win_valid = (win_lvl != '0);
    end
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 24,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [LVL_W-1:0] win_lvl,
    input  logic             irq_ack,
    output logic             irq_out,
    output logic [IDX_W-1:0] irq_idx,
    output logic [LVL_W-1:0] irq_lvl
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = win_valid ? ST_ASSERT : ST_IDLE;
            ST_ASSERT:  state_d = irq_ack ? ST_RECOVER : (win_valid ? ST_ASSERT : ST_IDLE);
            ST_RECOVER: state_d = win_valid ? ST_ASSERT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
            irq_idx <= '0;
            irq_lvl <= '0;
        end else if (state_d == ST_ASSERT) begin
            irq_out <= 1'b1;
            irq_idx <= win_idx;
            irq_lvl <= win_lvl;
        end else begin
            irq_out <= 1'b0;
            irq_idx <= '0;
            irq_lvl <= '0;
        end
    end

    assert_gap_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && irq_ack) |=> !irq_out);
    assert_quiet_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> (irq_idx == '0 && irq_lvl == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int ADDR_W  = 5,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    input  logic               reg_we,
    output logic [7:0]         reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               glb_en,
    input  logic [2:0]         cpu_ipl,
    output logic               irq_out,
    output logic [IDX_W-1:0]   irq_idx,
    output logic [2:0]         irq_lvl,
    input  logic               irq_ack
);
    logic [NUM_SRC-1:0]            flag_q;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
    logic [NUM_SRC-1:0]            ack_clr;
    logic                          win_valid;
    logic [IDX_W-1:0]              win_idx;
    logic [LVL_W-1:0]              win_lvl;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
        assign ack_clr[i] = irq_out && irq_ack && (irq_idx == IDX_W'(i));
    end

    irq_src_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .src_req(src_req),
        .ack_clr(ack_clr), .flag_q(flag_q), .lvl_q(lvl_q)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .flag_q(flag_q), .lvl_q(lvl_q), .glb_en(glb_en), .cpu_ipl(cpu_ipl),
        .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    irq_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx),
        .win_lvl(win_lvl), .irq_ack(irq_ack), .irq_out(irq_out),
        .irq_idx(irq_idx), .irq_lvl(irq_lvl)
    );

    assert_above_ipl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ($past(glb_en) && irq_lvl > $past(cpu_ipl)));
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
    localparam int N = 24;
    localparam int AW = 5;
    localparam int IW = $clog2(N);

    logic clk = 0;
    logic rst_n = 0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic reg_we = 0;
    logic [7:0] reg_rdata;
    logic [N-1:0] src_req = '0;
    logic glb_en = 0;
    logic [2:0] cpu_ipl = '0;
    logic irq_out;
    logic [IW-1:0] irq_idx;
    logic [2:0] irq_lvl;
    logic irq_ack = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    prio_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .src_req(src_req),
        .glb_en(glb_en), .cpu_ipl(cpu_ipl), .irq_out(irq_out),
        .irq_idx(irq_idx), .irq_lvl(irq_lvl), .irq_ack(irq_ack)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_flag[N];
    int m_lvl[N];
    int m_st = 0, m_out = 0, m_idx = 0, m_lv = 0;

    always @(posedge clk) begin
        int best_l, best_i, ack_i, sw, this_sel;
        if (!rst_n) begin
            foreach (m_flag[k]) begin m_flag[k] = 0; m_lvl[k] = 0; end
            m_st = 0; m_out = 0; m_idx = 0; m_lv = 0;
        end else begin
            best_l = 0; best_i = 0;
            for (int i = 0; i < N; i++)
                if (m_flag[i] != 0 && glb_en && m_lvl[i] > int'(cpu_ipl) && m_lvl[i] > best_l) begin
                    best_l = m_lvl[i]; best_i = i;
                end
            for (int i = 0; i < N; i++) begin
                this_sel = (reg_we && int'(reg_addr) == i) ? 1 : 0;
                ack_i = (m_out != 0 && irq_ack && m_idx == i) ? 1 : 0;
                sw = (this_sel != 0 && !reg_wdata[3]) ? 1 : 0;
                m_flag[i] = (src_req[i] || (m_flag[i] != 0 && sw == 0 && ack_i == 0)) ? 1 : 0;
                if (this_sel != 0) m_lvl[i] = int'(reg_wdata[2:0]);
            end
            if (m_st == 1 && irq_ack) m_st = 2;
            else m_st = (best_l > 0) ? 1 : 0;
            m_out = (m_st == 1) ? 1 : 0;
            m_idx = (m_out != 0) ? best_i : 0;
            m_lv  = (m_out != 0) ? best_l : 0;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        int exp_rd;
        if (rst_n && !done) begin
            exp_rd = (int'(reg_addr) < N) ? m_flag[reg_addr] * 8 + m_lvl[reg_addr] : 0;
            chk("R9 irq_out", int'(irq_out), m_out);
            chk("R9 irq_idx", int'(irq_idx), m_idx);
            chk("R9 irq_lvl", int'(irq_lvl), m_lv);
            chk("R2 rdata", int'(reg_rdata), exp_rd);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic settle(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(int a, int d);
        reg_addr = AW'(a); reg_wdata = 8'(d); reg_we = 1;
        tick();
        reg_we = 0;
    endtask

    task automatic rd(int a, int exp, string tag);
        reg_addr = AW'(a);
        @(negedge clk);
        chk(tag, int'(reg_rdata), exp);
        tick();
    endtask

    task automatic pulse(int s);
        src_req[s] = 1'b1; tick(); src_req[s] = 1'b0;
    endtask

    task automatic see(int o, int idx, int lv, string tag);
        @(negedge clk);
        chk(tag, int'(irq_out), o);
        chk(tag, int'(irq_idx), idx);
        chk(tag, int'(irq_lvl), lv);
        tick();
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1;
        tick();
        // R1: reset state
        see(0, 0, 0, "R1 outputs after reset");
        rd(0, 0, "R1 reg0 after reset");
        rd(23, 0, "R1 reg23 after reset");
        // R2 / R4: level write, upper bits dropped, bit3=1 sets nothing
        wr(2, 8'hFD);
        rd(2, 8'h05, "R2 level and upper bits");
        rd(2, 8'h05, "R4 write one leaves flag clear");
        rd(30, 0, "R2 out of range address");
        // R3: pulse sets flag, flag holds
        pulse(2);
        rd(2, 8'h0D, "R3 flag set");
        settle(2);
        rd(2, 8'h0D, "R3 flag held");
        // R6: enable and IPL masking
        see(0, 0, 0, "R6 disabled by global enable");
        glb_en = 1; cpu_ipl = 3'd4;
        settle(2);
        see(1, 2, 5, "R6 level above ipl");
        cpu_ipl = 3'd5;
        settle(2);
        see(0, 0, 0, "R6 level equal ipl masked");
        cpu_ipl = 3'd0;
        // R7: highest level, then lowest index on tie
        wr(7, 8'h05); wr(9, 8'h06);
        pulse(7); pulse(9);
        settle(3);
        see(1, 9, 6, "R7 highest level wins");
        wr(9, 8'h0D);
        settle(3);
        see(1, 2, 5, "R7 tie lowest index");
        // R8: acknowledge clears the presented source, one-cycle gap
        irq_ack = 1; tick(); irq_ack = 0;
        @(negedge clk); chk("R8 gap after ack", int'(irq_out), 0);
        tick();
        @(negedge clk);
        chk("R8 reselect out", int'(irq_out), 1);
        chk("R8 reselect idx", int'(irq_idx), 7);
        tick();
        rd(2, 8'h05, "R8 acked flag cleared");
        // R4: software clear
        wr(7, 8'h05);
        rd(7, 8'h05, "R4 write zero clears");
        // R5: request against software clear
        src_req[9] = 1'b1;
        wr(9, 8'h05);
        rd(9, 8'h0D, "R5 request beats clear");
        settle(2);
        // R5: request against acknowledge (presenting 9)
        @(negedge clk); chk("R5 presenting 9", int'(irq_idx), 9);
        tick();
        irq_ack = 1; tick(); irq_ack = 0;
        rd(9, 8'h0D, "R5 request beats ack");
        src_req[9] = 1'b0;
        wr(9, 8'h05);
        // R6: level zero never eligible
        wr(4, 8'h00);
        pulse(4);
        settle(3);
        see(0, 0, 0, "R6 level zero ignored");
        rd(4, 8'h08, "R3 flag on level zero source");
        settle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule